// File: doc/BRIEF.md
# SMBus Indexed Register Target

This block is an SMBus target that holds a small bank of eight byte-wide registers. The bank contains output-enable, amplitude and edge-rate control fields, a read-back length register, and constant identification bytes. A host reaches any register through indexed block transfers. Each transfer names a starting index and then moves a run of consecutive bytes, and the index advances after every byte. On reads the target first reports how many bytes it intends to return, then streams data from the chosen index onward until the host refuses a byte.

The 7-bit bus address is picked from three values by a three-state strap. A front end that is outside this block reduces the strap to a 2-bit code. The block captures that code on the first rising of a power-good input and keeps it until reset. Before the capture the target ignores the bus. SCL and SDA come in raw and are resynchronised to the system clock. SDA leaves the block only as an open-drain pull-down enable. The control fields drive the clock-output logic next to the block directly.

Top module: `smb_idxreg`

## Requirements
- R1: The bus address is taken from the strap code when power-good first goes high. Code 00 gives 0x6B, code 01 gives 0x6C, and 10 or 11 give 0x6D. Later strap or power-good changes do not move it. Before capture, no address is acknowledged.
- R2: An address byte that does not match leaves SDA released in its ACK slot, and the rest of that transfer changes no register.
- R3: A write is: start, address with R/W=0, index byte, count byte X, data bytes, stop. The first X data bytes land at index, index+1, and so on. Every byte is acknowledged.
- R4: Data bytes sent beyond the count X are acknowledged and discarded.
- R5: A read is: start, address with R/W=0, index byte, repeated start, address with R/W=1. The target then returns a count byte followed by register bytes from the index upward. The index uses bits 2:0 of the index byte and wraps from 7 to 0. The target stops driving once the host answers a byte with NACK.
- R6: Bits 4:0 of byte 7 are writable and reset to 8. The count byte sent on a read equals this field, and bits 7:5 read 0.
- R7: Bytes 3, 4, 5 and 6 are fixed: 0x00, 0xFF, 0x01 (revision 0 in the upper nibble, vendor 1 in the lower) and DEV_ID (default 0xA7). Writes to them are acknowledged and dropped.
- R8: After reset, byte 0 is 0x1F (all outputs enabled), byte 1 is 0x02 (amplitude code 10), byte 2 is 0x1F (all fast edges) and byte 7 is 0x08. Bits outside each field read 0.
- R9: `out_en[i]` is byte 0 bit i, `amp_sel` is byte 1 bits 1:0, and `slew_fast[i]` is byte 2 bit i. Each follows a write on the cycle after it is committed.
- R10: A stop that arrives inside a data byte abandons that byte and leaves every register unchanged. The target returns to idle and answers the next transfer normally.
- R11: SDA is only ever pulled low. The pull-down turns on only while the synchronised SCL is low, and it is off whenever the target is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| pwr_good | input | 1 | Power-good; first high captures the strap |
| strap_code | input | 2 | Decoded three-state strap level |
| out_en | output | NUM_OUT | Per-output enable, 1 = enabled |
| amp_sel | output | 2 | Output amplitude code |
| slew_fast | output | NUM_OUT | Per-output edge rate, 1 = fast |

## Verification
The bench targets several corner cases:
- An index near the top of the bank, so that a read crosses from byte 7 to byte 0. An unwrapped counter would return fixed or stale bytes instead.
- A write carrying more bytes than its count. A design that ignores the count would clobber the neighbouring amplitude field.
- A stop cut into the middle of a data byte. A target that commits partial bytes or stays mid-frame would alter a control field, or fail to answer the next address.
- Strap changes and power-good toggles after capture, which would retarget a design that re-latches.
- Writes aimed at the fixed bytes, and shrinking the read-back length, which shows up directly in the reported count byte.

// File: rtl/smbrb_pkg.sv
package smbrb_pkg;

  localparam int NREG = 8;
  localparam int IDXW = 3;
  localparam int CNTW = 5;

  localparam int IX_OE   = 0;
  localparam int IX_AMP  = 1;
  localparam int IX_SLEW = 2;
  localparam int IX_FILL = 4;
  localparam int IX_REV  = 5;
  localparam int IX_DEV  = 6;
  localparam int IX_CNT  = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } st_e;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_INDEX,
    RL_COUNT,
    RL_DATA
  } role_e;

  function automatic logic [6:0] strap_addr(input logic [1:0] code);
    case (code)
      2'b00:   return 7'h6B;
      2'b01:   return 7'h6C;
      default: return 7'h6D;
    endcase
  endfunction

  function automatic logic [7:0] low_ones(input int n);
    logic [7:0] m;
    m = 8'h00;
    for (int b = 0; b < 8; b++) begin
      if (b < n) m[b] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [7:0] wr_mask(input int i, input int nout);
    case (i)
      IX_OE, IX_SLEW: return low_ones(nout);
      IX_AMP:         return 8'h03;
      IX_CNT:         return low_ones(CNTW);
      default:        return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rst_val(input int i, input int nout);
    case (i)
      IX_OE, IX_SLEW: return low_ones(nout);
      IX_AMP:         return 8'h02;
      IX_CNT:         return 8'h08;
      default:        return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] fixed_val(input int i, input logic [7:0] dev);
    case (i)
      IX_FILL: return 8'hFF;
      IX_REV:  return 8'h01;
      IX_DEV:  return dev;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [IDXW-1:0] next_index(input logic [IDXW-1:0] i);
    return i + 1'b1;
  endfunction

endpackage

// File: rtl/smbrb_sync.sv
module smbrb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_p;
  logic              sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smbrb_strap.sv
module smbrb_strap import smbrb_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic [1:0] strap_code,
  output logic       addr_ok,
  output logic [6:0] my_addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_ok <= 1'b0;
      my_addr <= 7'h00;
    end else if (pwr_good && !addr_ok) begin
      addr_ok <= 1'b1;
      my_addr <= strap_addr(strap_code);
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ok |=> (addr_ok && $stable(my_addr))); // R1

endmodule

// File: rtl/smbrb_regfile.sv
module smbrb_regfile import smbrb_pkg::*; #(
  parameter int         NUM_OUT = 5,
  parameter logic [7:0] DEV_ID  = 8'hA7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDXW-1:0]    wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [IDXW-1:0]    rd_idx,
  output logic [7:0]         rd_data,
  output logic [NUM_OUT-1:0] out_en,
  output logic [1:0]         amp_sel,
  output logic [NUM_OUT-1:0] slew_fast,
  output logic [CNTW-1:0]    rd_count
);

  logic [7:0] bytes_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_byte
    localparam logic [7:0] MASK = wr_mask(g, NUM_OUT);
    if (MASK != 8'h00) begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= rst_val(g, NUM_OUT);
        end else if (wr_en && wr_idx == IDXW'(g)) begin
          q <= wr_data & MASK;
        end
      end
      assign bytes_q[g] = q;
    end else begin : g_ro
      assign bytes_q[g] = fixed_val(g, DEV_ID);
    end
  end

  assign rd_data   = bytes_q[rd_idx];
  assign out_en    = bytes_q[IX_OE][NUM_OUT-1:0];
  assign amp_sel   = bytes_q[IX_AMP][1:0];
  assign slew_fast = bytes_q[IX_SLEW][NUM_OUT-1:0];
  assign rd_count  = bytes_q[IX_CNT][CNTW-1:0];

  AST_AMP_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDXW'(IX_AMP)) |=> (amp_sel == $past(wr_data[1:0]))); // R9

endmodule

// File: rtl/smbrb_proto.sv
module smbrb_proto import smbrb_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_s,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic            addr_ok,
  input  logic [6:0]      my_addr,
  input  logic [7:0]      rd_data,
  input  logic [CNTW-1:0] rd_count,
  output logic [IDXW-1:0] rd_idx,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [7:0]      wr_data,
  output logic            sda_oe
);

  st_e             state;
  role_e           role;
  logic [3:0]      bitcnt;
  logic [7:0]      rx_sh;
  logic [7:0]      tx_sh;
  logic [7:0]      wcnt;
  logic [IDXW-1:0] idx;
  logic            next_tx;
  logic            tx_first;
  logic            got_ack;

  logic       byte_in;
  logic       addr_hit;
  logic [7:0] cnt_byte;

  assign byte_in  = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
  assign addr_hit = addr_ok && (rx_sh[7:1] == my_addr);
  assign cnt_byte = {{(8-CNTW){1'b0}}, rd_count};
  assign rd_idx   = tx_first ? idx : next_index(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      role     <= RL_ADDR;
      bitcnt   <= 4'd0;
      rx_sh    <= 8'h00;
      tx_sh    <= 8'h00;
      wcnt     <= 8'h00;
      idx      <= '0;
      next_tx  <= 1'b0;
      tx_first <= 1'b0;
      got_ack  <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= 8'h00;
      sda_oe   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state   <= ST_RX;
        role    <= RL_ADDR;
        bitcnt  <= 4'd0;
        sda_oe  <= 1'b0;
        next_tx <= 1'b0;
        got_ack <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && bitcnt < 4'd8) begin
              rx_sh  <= {rx_sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_in) begin
              sda_oe <= 1'b1;
              state  <= ST_RXACK;
              case (role)
                RL_ADDR: begin
                  if (addr_hit) begin
                    next_tx <= rx_sh[0];
                    role    <= RL_INDEX;
                  end else begin
                    sda_oe <= 1'b0;
                    state  <= ST_IDLE;
                  end
                end
                RL_INDEX: begin
                  idx  <= rx_sh[IDXW-1:0];
                  role <= RL_COUNT;
                end
                RL_COUNT: begin
                  wcnt <= rx_sh;
                  role <= RL_DATA;
                end
                default: begin
                  if (wcnt != 8'h00) begin
                    wr_en   <= 1'b1;
                    wr_idx  <= idx;
                    wr_data <= rx_sh;
                    wcnt    <= wcnt - 8'h01;
                  end
                  idx <= next_index(idx);
                end
              endcase
            end
          end
          ST_RXACK: begin
            if (scl_fall) begin
              bitcnt <= 4'd0;
              if (next_tx) begin
                state    <= ST_TX;
                tx_sh    <= cnt_byte;
                tx_first <= 1'b1;
                sda_oe   <= ~cnt_byte[7];
              end else begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe  <= 1'b0;
                state   <= ST_TXACK;
                got_ack <= 1'b0;
              end else begin
                bitcnt <= bitcnt + 4'd1;
                tx_sh  <= {tx_sh[6:0], 1'b0};
                sda_oe <= ~tx_sh[6];
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              if (sda_s) begin
                state <= ST_IDLE;
              end else begin
                got_ack  <= 1'b1;
                tx_sh    <= rd_data;
                tx_first <= 1'b0;
                if (!tx_first) idx <= next_index(idx);
              end
            end else if (scl_fall && got_ack) begin
              state   <= ST_TX;
              bitcnt  <= 4'd0;
              got_ack <= 1'b0;
              sda_oe  <= ~tx_sh[7];
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R11

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R11

  AST_WRITE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(scl_fall)); // R3

endmodule

// File: rtl/smb_idxreg.sv
module smb_idxreg import smbrb_pkg::*; #(
  parameter int         NUM_OUT     = 5,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] DEV_ID      = 8'hA7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  input  logic               pwr_good,
  input  logic [1:0]         strap_code,
  output logic [NUM_OUT-1:0] out_en,
  output logic [1:0]         amp_sel,
  output logic [NUM_OUT-1:0] slew_fast
);

  logic            scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic            addr_ok;
  logic [6:0]      my_addr;
  logic [IDXW-1:0] rd_idx, wr_idx;
  logic [7:0]      rd_data, wr_data;
  logic            wr_en;
  logic [CNTW-1:0] rd_count;

  smbrb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smbrb_strap u_strap (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strap_code(strap_code),
    .addr_ok(addr_ok), .my_addr(my_addr)
  );

  smbrb_proto u_proto (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .addr_ok(addr_ok), .my_addr(my_addr),
    .rd_data(rd_data), .rd_count(rd_count), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  smbrb_regfile #(.NUM_OUT(NUM_OUT), .DEV_ID(DEV_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .out_en(out_en), .amp_sel(amp_sel), .slew_fast(slew_fast),
    .rd_count(rd_count)
  );

  AST_WRITE_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> addr_ok); // R1

endmodule

// File: tb/smb_idxreg_tb.sv
module smb_idxreg_tb;

  localparam int Q = 6;
  localparam logic [7:0] DEV = 8'hA7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic pwr_good = 1'b0;
  logic [1:0] strap_code = 2'b00;
  logic sda_oe;
  logic [4:0] out_en, slew_fast;
  logic [1:0] amp_sel;
  wire sda_line = sda_m & ~sda_oe;

  int ntests = 0;
  int nfail = 0;
  bit done = 0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  logic [7:0] expr [8];

  always #2 clk = ~clk;

  smb_idxreg u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .pwr_good(pwr_good), .strap_code(strap_code),
    .out_en(out_en), .amp_sel(amp_sel), .slew_fast(slew_fast)
  );

  function automatic logic [7:0] tb_mask(input int i);
    if (i == 0 || i == 2 || i == 7) return 8'h1F;
    if (i == 1) return 8'h03;
    return 8'h00;
  endfunction

  function automatic logic [7:0] tb_fixed(input int i);
    if (i == 4) return 8'hFF;
    if (i == 5) return 8'h01;
    if (i == 6) return DEV;
    return 8'h00;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) expr[i] = tb_fixed(i);
    expr[0] = 8'h1F; expr[1] = 8'h02; expr[2] = 8'h1F; expr[7] = 8'h08;
  endtask

  task automatic model_write(input int idx, input int cnt, input int n);
    for (int i = 0; i < n; i++) begin
      int j;
      j = (idx + i) % 8;
      if (i < cnt && tb_mask(j) != 8'h00) expr[j] = wbuf[i] & tb_mask(j);
    end
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    ntests++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait(); qwait();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qwait(); scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    b = sda_line; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic put_byte(input logic [7:0] d, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = !a;
  endtask

  task automatic get_byte(output logic [7:0] d, input bit ack_it);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(!ack_it);
  endtask

  task automatic probe(input logic [6:0] a, output bit ack);
    bus_start();
    put_byte({a, 1'b0}, ack);
    bus_stop();
  endtask

  task automatic write_block(input logic [6:0] a, input int idx, input int cnt,
                             input int n, output bit ok);
    bit k;
    bus_start();
    put_byte({a, 1'b0}, k); ok = k;
    put_byte(8'(idx), k);   ok = ok & k;
    put_byte(8'(cnt), k);   ok = ok & k;
    for (int i = 0; i < n; i++) begin
      put_byte(wbuf[i], k);
      ok = ok & k;
    end
    bus_stop();
  endtask

  task automatic read_block(input logic [6:0] a, input int idx, input int n,
                            output bit ok, output logic [7:0] cnt);
    bit k;
    bus_start();
    put_byte({a, 1'b0}, k); ok = k;
    put_byte(8'(idx), k);   ok = ok & k;
    bus_start();
    put_byte({a, 1'b1}, k); ok = ok & k;
    get_byte(cnt, 1'b1);
    for (int i = 0; i < n; i++) get_byte(rbuf[i], i != n - 1);
    bus_stop();
  endtask

  task automatic do_reset(input logic [1:0] code, input logic pg);
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    strap_code = code; pwr_good = pg;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    model_reset();
  endtask

  task automatic check_outputs(input string req);
    check({req, " out_en"}, 32'(out_en), 32'(expr[0][4:0]));
    check({req, " amp_sel"}, 32'(amp_sel), 32'(expr[1][1:0]));
    check({req, " slew_fast"}, 32'(slew_fast), 32'(expr[2][4:0]));
  endtask

  task automatic read_check(input int idx, input int n, input string req);
    bit ok;
    logic [7:0] cnt;
    read_block(7'h6C, idx, n, ok, cnt);
    check({req, " read acks"}, 32'(ok), 32'd1);
    check("R6 count byte", 32'(cnt), 32'(expr[7]));
    for (int i = 0; i < n; i++) check({req, " read data"}, 32'(rbuf[i]), 32'(expr[(idx + i) % 8]));
    check("R11 released after read", 32'(sda_oe), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    bit ok;
    logic [7:0] cnt;
    void'($urandom(32'h5EED_0101));

    // R8, R11: reset state
    do_reset(2'b00, 1'b0);
    check("R8 reset out_en", 32'(out_en), 32'h1F);
    check("R8 reset amp_sel", 32'(amp_sel), 32'h2);
    check("R8 reset slew_fast", 32'(slew_fast), 32'h1F);
    check("R11 reset sda_oe", 32'(sda_oe), 32'd0);

    // R1: silent before power-good, then strap 00 -> 0x6B
    probe(7'h6B, ok); check("R1 no ack before capture", 32'(ok), 32'd0);
    pwr_good = 1'b1; repeat (3) @(negedge clk);
    probe(7'h6B, ok); check("R1 strap 00 address", 32'(ok), 32'd1);
    probe(7'h6C, ok); check("R2 other address nacked", 32'(ok), 32'd0);

    // R1: strap high -> 0x6D
    do_reset(2'b10, 1'b1);
    probe(7'h6D, ok); check("R1 strap 10 address", 32'(ok), 32'd1);
    probe(7'h6B, ok); check("R2 low address nacked", 32'(ok), 32'd0);

    // R1: strap mid -> 0x6C, held across later changes
    do_reset(2'b01, 1'b1);
    repeat (3) @(negedge clk);
    strap_code = 2'b00; pwr_good = 1'b0; repeat (4) @(negedge clk);
    pwr_good = 1'b1; repeat (4) @(negedge clk);
    probe(7'h6C, ok); check("R1 address held", 32'(ok), 32'd1);
    probe(7'h6B, ok); check("R1 no re-latch", 32'(ok), 32'd0);

    // R5, R6, R7, R8: full read of defaults
    read_check(0, 8, "R5 R8 defaults");

    // R3, R4: count 1 with an extra byte
    wbuf[0] = 8'h03; wbuf[1] = 8'h00;
    write_block(7'h6C, 0, 1, 2, ok);
    check("R3 R4 write acks", 32'(ok), 32'd1);
    model_write(0, 1, 2);
    repeat (2) @(negedge clk);
    check_outputs("R4 extra discarded");

    // R7: fixed bytes ignore writes
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    write_block(7'h6C, 3, 4, 4, ok);
    check("R7 write acks", 32'(ok), 32'd1);
    read_check(3, 4, "R7 fixed bytes");

    // R6: shrink read-back length, upper bits masked
    wbuf[0] = 8'hE3;
    write_block(7'h6C, 7, 1, 1, ok);
    model_write(7, 1, 1);
    read_check(7, 1, "R6 count field");

    // R5: wrap from 7 to 0 (index byte upper bits ignored)
    read_block(7'h6C, 8'hF6, 4, ok, cnt);
    check("R5 wrap acks", 32'(ok), 32'd1);
    for (int i = 0; i < 4; i++) check("R5 wrap data", 32'(rbuf[i]), 32'(expr[(6 + i) % 8]));

    // R2: mismatched address writes nothing
    wbuf[0] = 8'h01;
    write_block(7'h6D, 1, 1, 1, ok);
    check("R2 mismatch nack", 32'(ok), 32'd0);
    repeat (2) @(negedge clk);
    check_outputs("R2 no effect");

    // R10: stop inside a data byte
    bus_start();
    put_byte({7'h6C, 1'b0}, ok);
    put_byte(8'h01, ok);
    put_byte(8'h01, ok);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    repeat (2) @(negedge clk);
    check("R10 amp kept", 32'(amp_sel), 32'(expr[1][1:0]));
    check("R10 released", 32'(sda_oe), 32'd0);
    probe(7'h6C, ok); check("R10 answers next", 32'(ok), 32'd1);

    // R3, R5, R9: random traffic
    for (int it = 0; it < 12; it++) begin
      int idx, c, n, ridx, rn;
      idx = int'($urandom % 8);
      c = 1 + int'($urandom % 4);
      n = c + int'($urandom % 2);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      write_block(7'h6C, idx, c, n, ok);
      check("R3 random write acks", 32'(ok), 32'd1);
      model_write(idx, c, n);
      repeat (2) @(negedge clk);
      check_outputs("R9 random");
      ridx = int'($urandom % 8);
      rn = 1 + int'($urandom % 8);
      read_check(ridx, rn, "R5 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule